// File: doc/BRIEF.md
# Watchdog Timer with Selectable Prescaler

This block is a watchdog that runs from its own slow RC tick, so it keeps counting while the core clock is stopped in sleep. A base counter of `TICK_W` bits counts RC ticks. Software can place a 7-stage prescaler in front of that counter and pick a division ratio from 1:1 to 1:128 with a three-bit select. The prescaler assignment and the ratio come from an option register that lives outside the block. A configuration enable that is tied low keeps the watchdog off for good.

The core issues two commands as single-cycle strobes on the core clock: clear-watchdog and sleep. A toggle handshake carries each command into the RC domain. Commands that arrive while a transfer is still in flight are merged and sent next. Either command zeroes the counter and, when the prescaler is assigned, the prescaler as well. When the counter runs out, the block sends a one-tick reset pulse. If the sleep state was set, the pulse goes out on the wake-up reset pin and the sleep state ends. Otherwise the pulse goes out on the device reset pin. A time-out status bit drops when a watchdog reset fires and is set again by either command.

Top module: `wdt_top`

## Requirements
- R1: After `rstN` is asserted, `devRst` and `wakeRst` are low and `toStatus` is high.
- R2: With `psaWdt` low, the watchdog times out once every 2^TICK_W RC ticks, whatever the value of `ratioSel`.
- R3: With `psaWdt` high, the time-out period is 2^TICK_W × 2^`ratioSel` RC ticks, so select values 0..7 give division by 1, 2, 4 … 128.
- R4: A clear command resets the counter and, when the prescaler is assigned, the prescaler too. The next time-out then comes one full period after the command reaches the RC domain, and clears repeated within a period prevent any reset.
- R5: A sleep command zeroes the counter and the assigned prescaler and sets the sleep state. The next time-out pulses `wakeRst`, not `devRst`, and ends the sleep state.
- R6: A time-out outside sleep pulses `devRst`. `devRst` and `wakeRst` are never high together.
- R7: With `cfgEnable` low, the counter is held at zero and no reset pulse is produced.
- R8: `toStatus` is low from the tick that a watchdog reset pulse appears, and is set high by a clear or a sleep command.
- R9: Strobes reach the RC domain through a request/acknowledge toggle handshake. A strobe that arrives while a transfer is busy is held and delivered with the next transfer, and is not lost.
- R10: Each reset pulse is exactly one RC tick wide.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| coreClk | input | 1 | Core clock; stops in sleep |
| rcClk | input | 1 | Free-running watchdog RC tick |
| rstN | input | 1 | Asynchronous active-low power-on reset for both domains |
| cfgEnable | input | 1 | Configuration enable; low disables the watchdog |
| psaWdt | input | 1 | High assigns the prescaler to the watchdog |
| ratioSel | input | SEL_W | Prescaler ratio select, division 2^ratioSel |
| clrStrobe | input | 1 | Clear-watchdog command, one coreClk cycle |
| sleepStrobe | input | 1 | Sleep command, one coreClk cycle |
| devRst | output | 1 | Device reset pulse on a time-out outside sleep (rcClk domain) |
| wakeRst | output | 1 | Wake-up reset pulse on a time-out during sleep (rcClk domain) |
| toStatus | output | 1 | Time-out status; low after a watchdog reset |

## Verification
The bench builds the block with `TICK_W = 4`, so the base period is 16 RC ticks, and keeps the default `SEL_W = 3`. With these values the longest ratio, 1:128, takes 2048 ticks, so every ratio can be measured tick-exactly between consecutive pulses in a short run. The small base also lets the bench clear the watchdog several times within one period. At 1:32 the prescaler phase can be as much as 31 ticks, so if a clear failed to reset the prescaler, the delay from clear to time-out would visibly fall short.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  // Command strobes delivered in the RC domain
  typedef struct packed {
    logic clr;
    logic slp;
  } wdtCmd_t;

  // Control-to-datapath strobes
  typedef struct packed {
    logic zero;  // reset counter (and assigned prescaler)
    logic run;   // advance on this tick
  } wdtCtl_t;
endpackage

// File: rtl/wdt_cdc.sv
module wdt_cdc
  import wdt_pkg::*;
#(
  parameter int SYNC_N = 2
) (
  input  logic    coreClk,
  input  logic    rcClk,
  input  logic    rstN,
  input  logic    clrStrobe,
  input  logic    sleepStrobe,
  output wdtCmd_t cmd
);
  // core side
  logic    reqTgl;
  wdtCmd_t payload, pend, nextCmd;
  logic [SYNC_N-1:0] ackSync;
  logic    busy;
  // rc side
  logic [SYNC_N:0] reqSync;
  logic    fire;

  assign busy    = reqTgl ^ ackSync[SYNC_N-1];
  assign nextCmd = '{clr: pend.clr | clrStrobe, slp: pend.slp | sleepStrobe};

  always_ff @(posedge coreClk or negedge rstN) begin
    if (!rstN) begin
      reqTgl  <= 1'b0;
      payload <= '0;
      pend    <= '0;
    end else if (!busy && (nextCmd.clr || nextCmd.slp)) begin
      payload <= nextCmd;
      reqTgl  <= ~reqTgl;
      pend    <= '0;
    end else begin
      pend    <= nextCmd;
    end
  end

  // ack comes back from the last request-sync stage
  always_ff @(posedge coreClk or negedge rstN) begin
    if (!rstN) ackSync <= '0;
    else       ackSync <= {ackSync[SYNC_N-2:0], reqSync[SYNC_N]};
  end

  always_ff @(posedge rcClk or negedge rstN) begin
    if (!rstN) reqSync <= '0;
    else       reqSync <= {reqSync[SYNC_N-1:0], reqTgl};
  end

  assign fire    = reqSync[SYNC_N] ^ reqSync[SYNC_N-1];
  assign cmd.clr = fire & payload.clr;
  assign cmd.slp = fire & payload.slp;

  // R9: payload held steady while a transfer is outstanding
  p_payload_stable_r9: assert property (@(posedge coreClk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(payload));
endmodule

// File: rtl/wdt_datapath.sv
module wdt_datapath
  import wdt_pkg::*;
#(
  parameter int TICK_W = 8,
  parameter int SEL_W  = 3
) (
  input  logic             rcClk,
  input  logic             rstN,
  input  wdtCtl_t          ctl,
  input  logic             psaAsync,
  input  logic [SEL_W-1:0] selAsync,
  output logic             wrapEv
);
  localparam int PRE_W = (1 << SEL_W) - 1;

  logic [TICK_W-1:0] cnt;
  logic [PRE_W-1:0]  pre, preMask;
  logic [1:0]        psaSync;
  logic [SEL_W-1:0]  selS1, selS2;
  logic              step;

  always_ff @(posedge rcClk or negedge rstN) begin
    if (!rstN) begin
      psaSync <= '0;
      selS1   <= '0;
      selS2   <= '0;
    end else begin
      psaSync <= {psaSync[0], psaAsync};
      selS1   <= selAsync;
      selS2   <= selS1;
    end
  end

  assign preMask = (PRE_W'(1) << selS2) - PRE_W'(1);
  assign step    = !psaSync[1] || ((pre & preMask) == preMask);
  assign wrapEv  = ctl.run && !ctl.zero && step && (&cnt);

  always_ff @(posedge rcClk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
      pre <= '0;
    end else if (ctl.zero) begin
      cnt <= '0;
      if (psaSync[1]) pre <= '0;
    end else if (ctl.run) begin
      if (psaSync[1]) pre <= pre + PRE_W'(1);
      if (step)       cnt <= cnt + TICK_W'(1);
    end
  end

  // R4: a zero strobe leaves counter (and assigned prescaler) at zero
  p_zeroed_r4: assert property (@(posedge rcClk) disable iff (!rstN)
    (ctl.zero && psaSync[1]) |=> (cnt == '0 && pre == '0));
endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pkg::*;
(
  input  logic    rcClk,
  input  logic    rstN,
  input  logic    cfgEnable,
  input  wdtCmd_t cmd,
  input  logic    wrapEv,
  output wdtCtl_t ctl,
  output logic    devRst,
  output logic    wakeRst,
  output logic    toStatus
);
  logic sleeping;

  assign ctl.zero = cmd.clr | cmd.slp | !cfgEnable;
  assign ctl.run  = cfgEnable;

  always_ff @(posedge rcClk or negedge rstN) begin
    if (!rstN) begin
      sleeping <= 1'b0;
      devRst   <= 1'b0;
      wakeRst  <= 1'b0;
      toStatus <= 1'b1;
    end else begin
      devRst  <= wrapEv & !sleeping;
      wakeRst <= wrapEv & sleeping;
      if (wrapEv) begin
        sleeping <= 1'b0;
        toStatus <= 1'b0;
      end else if (cmd.clr || cmd.slp) begin
        toStatus <= 1'b1;
        if (cmd.slp) sleeping <= 1'b1;
      end
    end
  end

  p_pulse_onehot_r6: assert property (@(posedge rcClk) disable iff (!rstN)
    $onehot0({devRst, wakeRst}));
  p_single_tick_r10: assert property (@(posedge rcClk) disable iff (!rstN)
    (devRst || wakeRst) |=> !(devRst || wakeRst));
  p_to_low_r8: assert property (@(posedge rcClk) disable iff (!rstN)
    (devRst || wakeRst) |-> !toStatus);
  p_off_silent_r7: assert property (@(posedge rcClk) disable iff (!rstN)
    !cfgEnable |=> !(devRst || wakeRst));
  p_wake_ends_sleep_r5: assert property (@(posedge rcClk) disable iff (!rstN)
    wakeRst |-> !sleeping);
endmodule

// File: rtl/wdt_top.sv
module wdt_top
  import wdt_pkg::*;
#(
  parameter int TICK_W = 8,
  parameter int SEL_W  = 3
) (
  input  logic             coreClk,
  input  logic             rcClk,
  input  logic             rstN,
  input  logic             cfgEnable,
  input  logic             psaWdt,
  input  logic [SEL_W-1:0] ratioSel,
  input  logic             clrStrobe,
  input  logic             sleepStrobe,
  output logic             devRst,
  output logic             wakeRst,
  output logic             toStatus
);
  wdtCmd_t cmd;
  wdtCtl_t ctl;
  logic    wrapEv;

  wdt_cdc #(.SYNC_N(2)) u_cdc (
    .coreClk(coreClk), .rcClk(rcClk), .rstN(rstN),
    .clrStrobe(clrStrobe), .sleepStrobe(sleepStrobe), .cmd(cmd)
  );

  wdt_ctrl u_ctrl (
    .rcClk(rcClk), .rstN(rstN), .cfgEnable(cfgEnable), .cmd(cmd),
    .wrapEv(wrapEv), .ctl(ctl), .devRst(devRst), .wakeRst(wakeRst),
    .toStatus(toStatus)
  );

  wdt_datapath #(.TICK_W(TICK_W), .SEL_W(SEL_W)) u_dp (
    .rcClk(rcClk), .rstN(rstN), .ctl(ctl), .psaAsync(psaWdt),
    .selAsync(ratioSel), .wrapEv(wrapEv)
  );
endmodule

// File: tb/sim_wdt_top.sv
module sim_wdt_top;
  localparam int TICK_W = 4;
  localparam int BASE   = 1 << TICK_W;

  logic coreClk = 0, rcClk = 0, rstN = 0;
  logic cfgEnable = 1, psaWdt = 0, clrStrobe = 0, sleepStrobe = 0;
  logic [2:0] ratioSel = 0;
  logic devRst, wakeRst, toStatus;

  int nTests = 0, nFail = 0;
  int tick = 0, pulseCount = 0, lastTick = 0, wideCount = 0;
  logic lastWake = 0, prevPulse = 0;
  int coreCycles = 0;

  always #4  coreClk = ~coreClk;   // 125 MHz
  always #20 rcClk   = ~rcClk;

  wdt_top #(.TICK_W(TICK_W), .SEL_W(3)) u0 (
    .coreClk(coreClk), .rcClk(rcClk), .rstN(rstN), .cfgEnable(cfgEnable),
    .psaWdt(psaWdt), .ratioSel(ratioSel), .clrStrobe(clrStrobe),
    .sleepStrobe(sleepStrobe), .devRst(devRst), .wakeRst(wakeRst),
    .toStatus(toStatus)
  );

  // monitor in the RC domain, away from the active edge
  always @(negedge rcClk) begin
    tick++;
    if (devRst || wakeRst) begin
      pulseCount++;
      lastTick = tick;
      lastWake = wakeRst;
      if (prevPulse) wideCount++;
    end
    prevPulse = devRst || wakeRst;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic strobe(input bit isSleep);
    @(negedge coreClk);
    if (isSleep) sleepStrobe = 1; else clrStrobe = 1;
    @(negedge coreClk);
    sleepStrobe = 0; clrStrobe = 0;
  endtask

  task automatic waitPulse(input int limit, output bit got);
    int c = pulseCount;
    got = 0;
    for (int i = 0; i < limit; i++) begin
      @(negedge rcClk);
      if (pulseCount != c) begin got = 1; break; end
    end
  endtask

  task automatic waitTicks(input int n);
    for (int i = 0; i < n; i++) @(negedge rcClk);
  endtask

  task automatic setCfg(input bit psa, input int sel);
    psaWdt = psa; ratioSel = 3'(sel);
    waitTicks(4);
    strobe(0);
  endtask

  task automatic t_reset;
    check(devRst == 0, "R1 devRst", devRst, 0);
    check(wakeRst == 0, "R1 wakeRst", wakeRst, 0);
    check(toStatus == 1, "R1 toStatus", toStatus, 1);
  endtask

  task automatic t_period(input bit psa, input int sel, input string req);
    bit got; int t0, exp;
    exp = psa ? (BASE << sel) : BASE;
    setCfg(psa, sel);
    waitPulse(exp + 20, got);
    t0 = lastTick;
    waitPulse(exp + 20, got);
    check(got && (lastTick - t0) == exp, req, lastTick - t0, exp);
  endtask

  task automatic t_clear;
    bit got; int c, t0, exp;
    // R4: repeated clears within a period hold off any reset
    setCfg(0, 0);
    c = pulseCount;
    for (int i = 0; i < 12; i++) begin
      waitTicks(BASE / 2);
      strobe(0);
    end
    check(pulseCount == c, "R4 keepalive pulses", pulseCount - c, 0);
    // R4: prescaler also zeroed; full period after clear
    setCfg(1, 5);
    exp = BASE << 5;
    waitPulse(exp + 20, got);
    waitTicks(13);
    t0 = tick;
    strobe(0);
    waitPulse(exp + 20, got);
    check(got && (lastTick - t0) >= exp && (lastTick - t0) <= exp + 4,
          "R4 clear-to-timeout", lastTick - t0, exp + 2);
  endtask

  task automatic t_sleep;
    bit got; int t0;
    setCfg(0, 0);
    waitTicks(5);
    t0 = tick;
    strobe(1);
    waitPulse(BASE + 20, got);
    check(got && lastWake == 1, "R5 wake pulse", lastWake, 1);
    check((lastTick - t0) >= BASE && (lastTick - t0) <= BASE + 4,
          "R5 full period in sleep", lastTick - t0, BASE + 2);
    check(toStatus == 0, "R8 toStatus after timeout", toStatus, 0);
    waitPulse(BASE + 20, got);
    check(got && lastWake == 0, "R6 device reset after wake", lastWake, 0);
    check(wideCount == 0, "R10 pulse width", wideCount, 0);
  endtask

  task automatic t_status;
    strobe(0);
    waitTicks(6);
    check(toStatus == 1, "R8 toStatus set by clear", toStatus, 1);
  endtask

  task automatic t_merge;
    bit got;
    setCfg(0, 0);
    waitTicks(4);
    @(negedge coreClk); clrStrobe = 1;
    @(negedge coreClk); clrStrobe = 0; sleepStrobe = 1;
    @(negedge coreClk); sleepStrobe = 0;
    waitPulse(BASE + 20, got);
    check(got && lastWake == 1, "R9 merged sleep delivered", lastWake, 1);
  endtask

  task automatic t_disable;
    int c;
    cfgEnable = 0;
    waitTicks(3);
    c = pulseCount;
    waitTicks(BASE * 6);
    check(pulseCount == c, "R7 no pulse when disabled", pulseCount - c, 0);
    cfgEnable = 1;
  endtask

  initial begin
    forever begin
      @(posedge coreClk);
      coreCycles++;
      if (coreCycles > 190000) begin
        nTests++; nFail++;
        $display("FAIL watchdog actual=%0d expected=%0d", coreCycles, 190000);
        $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge rcClk);
    t_reset();          // R1
    rstN = 1;
    waitTicks(2);
    t_period(0, 0, "R2 base period");
    t_period(0, 7, "R2 ratio ignored");
    t_period(1, 0, "R3 ratio 1:1");
    t_period(1, 3, "R3 ratio 1:8");
    t_period(1, 7, "R3 ratio 1:128");
    t_clear();
    t_sleep();
    t_status();
    t_merge();
    t_disable();
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule